// File: doc/BRIEF.md
# Nonvolatile SRAM Store/Recall Controller

A synthesizable behavioural model of a byte-wide static RAM in which every word has a shadow word in a nonvolatile array. The RAM side has chip enable, output enable, write enable and address inputs, a data input and a data output with a drive enable. All of these are sampled on a system clock. In normal operation the block acts as a plain SRAM. Bulk transfers between the two arrays move one word per clock and hold off every user access while they run. A STORE copies RAM to shadow. A RECALL clears the RAM and then copies shadow to RAM.

There are two ways to start a transfer. The first is a power-good input: a fall starts a STORE and a rise starts a RECALL. The second is an unlock sequence of six reads at fixed addresses. Any other access in the middle of a sequence aborts it. Power events that arrive while a transfer is running are held and served afterwards.

The array depth is a parameter and must be a power of two. The address bus is wider than the array. The full address is compared for unlock detection, and the low address bits index the array.

Top module: `nvs_ctrl`

## Requirements
- R1: When ce_ni is 1 the cycle is standby: no access is made and data_oe_o is 0. Reset leaves busy_o at 0, data_oe_o at 0, the unlock progress empty and both arrays at zero.
- R2: A read (ce_ni=0, we_ni=1, oe_ni=0 in an idle, powered cycle) sets data_oe_o to 1 in the same cycle, with data_o equal to the word at addr_i modulo DEPTH.
- R3: An internal read (ce_ni=0, we_ni=1, oe_ni=1) keeps data_oe_o at 0 but still counts as a read for unlock detection.
- R4: A write (ce_ni=0, we_ni=0, any oe_ni) keeps data_oe_o at 0 and stores data_i at the clock edge. The new value is readable from the following cycle.
- R5: Six consecutive reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0FC0 (all ADDR_W bits compared) start a STORE at the edge that samples the sixth read.
- R6: Six consecutive reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F, 0x0C63 start a RECALL at the edge that samples the sixth read.
- R7: A write, or a read at any address other than the next expected one, aborts unlock progress. A read at 0x0E38 that aborts counts as step one of a new sequence. Cycles without an access leave progress unchanged.
- R8: busy_o is 1 for exactly DEPTH cycles after a STORE trigger edge. During that time all accesses are ignored and data_oe_o stays 0. Afterwards the shadow holds the RAM image from the trigger.
- R9: busy_o is 1 for exactly 2*DEPTH cycles after a RECALL trigger edge: DEPTH cycles clearing the RAM, then DEPTH cycles copying shadow to RAM. The shadow is never changed by a RECALL.
- R10: A 1-to-0 change of pwr_good_i starts a STORE. While pwr_good_i is 0, all accesses are ignored.
- R11: A 0-to-1 change of pwr_good_i (sampled from reset, where the previous value counts as 0) starts a RECALL before any access is accepted.
- R12: Power changes seen during a transfer are remembered. Once idle, a pending STORE is served first, then a pending RECALL. No access is accepted while either is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_good_i | input | 1 | Supply good indication |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data, valid when data_oe_o is 1 |
| data_oe_o | output | 1 | Read data drive enable |
| busy_o | output | 1 | Transfer in progress |

## Verification
Read data and its drive enable follow the inputs combinationally in the same cycle. A write becomes visible from the cycle after the edge that takes it. busy_o appears in the cycle after a trigger edge and lasts DEPTH or 2*DEPTH cycles. The bench drives inputs on the falling edge and compares every output with a behavioural model one time unit before the next rising edge, when all of these are settled. It counts busy durations by sampling on falling edges starting from the first cycle after the trigger. Directed readbacks sample a quarter period after the inputs change.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_STORE  = 2'd1,
    XF_CLEAR  = 2'd2,
    XF_RECALL = 2'd3
  } xfer_e;

  localparam int unsigned UNLOCK_PREFIX = 5;

  localparam logic [15:0] UNLOCK_STORE_LAST  = 16'h0FC0;
  localparam logic [15:0] UNLOCK_RECALL_LAST = 16'h0C63;

  function automatic logic [15:0] unlock_addr(input logic [2:0] k);
    case (k)
      3'd0:    return 16'h0E38;
      3'd1:    return 16'h31C7;
      3'd2:    return 16'h03E0;
      3'd3:    return 16'h3C1F;
      3'd4:    return 16'h303F;
      default: return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/nvs_unlock_det.sv
module nvs_unlock_det
  import nvs_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sw_store_o,
  output logic              sw_recall_o
);

  localparam logic [2:0]        LAST_STEP  = 3'(UNLOCK_PREFIX);
  localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(16'h0E38);
  localparam logic [ADDR_W-1:0] STORE_A    = ADDR_W'(UNLOCK_STORE_LAST);
  localparam logic [ADDR_W-1:0] RECALL_A   = ADDR_W'(UNLOCK_RECALL_LAST);

  logic [2:0]        step_q, step_d;
  logic [ADDR_W-1:0] exp_addr;
  logic              rd, at_last, restart;

  assign rd       = acc_i & ~wr_i;
  assign at_last  = (step_q == LAST_STEP);
  assign exp_addr = ADDR_W'(unlock_addr(step_q));
  assign restart  = (addr_i == FIRST_ADDR);

  assign sw_store_o  = rd & at_last & (addr_i == STORE_A);
  assign sw_recall_o = rd & at_last & (addr_i == RECALL_A);

  always_comb begin
    step_d = step_q;
    if (acc_i) begin
      if (wr_i) begin
        step_d = 3'd0;
      end else if (at_last) begin
        step_d = (sw_store_o | sw_recall_o) ? 3'd0 : (restart ? 3'd1 : 3'd0);
      end else if (addr_i == exp_addr) begin
        step_d = step_q + 3'd1;
      end else begin
        step_d = restart ? 3'd1 : 3'd0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= 3'd0;
    else         step_q <= step_d;
  end

  p_write_aborts_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && wr_i) |=> (step_q == 3'd0));

  p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(step_q));

  p_trigger_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_store_o || sw_recall_o) |=> (step_q == 3'd0));

  p_step_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST_STEP);

endmodule

// File: rtl/nvs_xfer_fsm.sv
module nvs_xfer_fsm
  import nvs_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_good_i,
  input  logic             sw_store_i,
  input  logic             sw_recall_i,
  output xfer_e            state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             acc_en_o,
  output logic             busy_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  xfer_e            state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pwr_q, pend_st_q, pend_rc_q, pend_st_d, pend_rc_d;
  logic             fall, rise, st_any, rc_any, idle, at_last;

  assign fall    = pwr_q & ~pwr_good_i;
  assign rise    = ~pwr_q & pwr_good_i;
  assign st_any  = pend_st_q | fall;
  assign rc_any  = pend_rc_q | rise;
  assign idle    = (state_q == XF_IDLE);
  assign at_last = (idx_q == LAST);

  assign acc_en_o = idle & pwr_good_i & pwr_q & ~pend_st_q & ~pend_rc_q;
  assign busy_o   = ~idle;
  assign state_o  = state_q;
  assign idx_o    = idx_q;

  always_comb begin
    state_d   = state_q;
    idx_d     = at_last ? '0 : idx_q + IDX_W'(1);
    pend_st_d = st_any;
    pend_rc_d = rc_any;
    unique case (state_q)
      XF_IDLE: begin
        idx_d = '0;
        if (st_any) begin
          state_d   = XF_STORE;
          pend_st_d = 1'b0;
        end else if (rc_any) begin
          state_d   = XF_CLEAR;
          pend_rc_d = 1'b0;
        end else if (sw_store_i) begin
          state_d = XF_STORE;
        end else if (sw_recall_i) begin
          state_d = XF_CLEAR;
        end
      end
      XF_STORE:  if (at_last) state_d = XF_IDLE;
      XF_CLEAR:  if (at_last) state_d = XF_RECALL;
      XF_RECALL: if (at_last) state_d = XF_IDLE;
      default:   state_d = XF_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= XF_IDLE;
      idx_q     <= '0;
      pwr_q     <= 1'b0;
      pend_st_q <= 1'b0;
      pend_rc_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      idx_q     <= idx_d;
      pwr_q     <= pwr_good_i;
      pend_st_q <= pend_st_d;
      pend_rc_q <= pend_rc_d;
    end
  end

  p_store_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XF_STORE && !at_last) |=> (state_q == XF_STORE && idx_q == $past(idx_q) + IDX_W'(1)));

  p_store_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XF_STORE && at_last) |=> (state_q == XF_IDLE));

  p_clear_to_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == XF_CLEAR && at_last) |=> (state_q == XF_RECALL && idx_q == '0));

  p_fall_stores_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && fall) |=> (state_q == XF_STORE));

  p_rise_recalls_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && rise && !pend_st_q) |=> (state_q == XF_CLEAR));

  p_pending_store_first_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && pend_st_q) |=> (state_q == XF_STORE));

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays
  import nvs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xfer_e             state_i,
  input  logic [IDX_W-1:0]  xidx_i,
  input  logic              usr_we_i,
  input  logic [IDX_W-1:0]  usr_idx_i,
  input  logic [DATA_W-1:0] usr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] sram_q   [DEPTH];
  logic [DATA_W-1:0] shadow_q [DEPTH];

  logic              sr_we, sh_we;
  logic [IDX_W-1:0]  sr_idx;
  logic [DATA_W-1:0] sr_wd, sh_at, sr_at;

  assign sh_at     = shadow_q[xidx_i];
  assign sr_at     = sram_q[xidx_i];
  assign rd_data_o = sram_q[usr_idx_i];
  assign sh_we     = (state_i == XF_STORE);

  always_comb begin
    sr_we  = 1'b0;
    sr_idx = usr_idx_i;
    sr_wd  = usr_data_i;
    unique case (state_i)
      XF_IDLE:   sr_we = usr_we_i;
      XF_CLEAR: begin
        sr_we  = 1'b1;
        sr_idx = xidx_i;
        sr_wd  = '0;
      end
      XF_RECALL: begin
        sr_we  = 1'b1;
        sr_idx = xidx_i;
        sr_wd  = sh_at;
      end
      default:   sr_we = 1'b0;
    endcase
  end

  // reset models a blank part on first power-up
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) sram_q[i] <= '0;
    end else if (sr_we) begin
      sram_q[sr_idx] <= sr_wd;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) shadow_q[i] <= '0;
    end else if (sh_we) begin
      shadow_q[xidx_i] <= sr_at;
    end
  end

  p_store_copies_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == XF_STORE) |=> (shadow_q[$past(xidx_i)] == $past(sr_at)));

  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == XF_CLEAR) |=> (sram_q[$past(xidx_i)] == '0));

  p_copy_back_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == XF_RECALL) |=> (sram_q[$past(xidx_i)] == $past(sh_at)));

  p_shadow_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == XF_CLEAR || state_i == XF_RECALL) |=> (shadow_q[$past(xidx_i)] == $past(sh_at)));

endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_good_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  xfer_e             state;
  logic [IDX_W-1:0]  xidx;
  logic              acc_en, acc, wr, sw_store, sw_recall;
  logic [DATA_W-1:0] rd_data;

  assign acc       = acc_en & ~ce_ni;
  assign wr        = ~we_ni;
  assign data_oe_o = acc & we_ni & ~oe_ni;
  assign data_o    = data_oe_o ? rd_data : '0;

  nvs_unlock_det #(.ADDR_W(ADDR_W)) i_unlock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .wr_i        (wr),
    .addr_i      (addr_i),
    .sw_store_o  (sw_store),
    .sw_recall_o (sw_recall)
  );

  nvs_xfer_fsm #(.DEPTH(DEPTH)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_good_i  (pwr_good_i),
    .sw_store_i  (sw_store),
    .sw_recall_i (sw_recall),
    .state_o     (state),
    .idx_o       (xidx),
    .acc_en_o    (acc_en),
    .busy_o      (busy_o)
  );

  nvs_arrays #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_arrays (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .xidx_i     (xidx),
    .usr_we_i   (acc & wr),
    .usr_idx_i  (addr_i[IDX_W-1:0]),
    .usr_data_i (data_i),
    .rd_data_o  (rd_data)
  );

  p_standby_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |-> !data_oe_o);

  p_write_no_drive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_ni |-> !data_oe_o);

  p_internal_rd_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_o);

  p_busy_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !data_oe_o);

  p_power_low_blocks_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> !data_oe_o);

  p_trigger_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_store || sw_recall) |=> busy_o);

endmodule

// File: tb/test_nvs_ctrl.sv
module test_nvs_ctrl;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0, pwr_good = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic doe, busy;

  always #(CLK_P/2) clk = ~clk;

  nvs_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_nvs_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_good_i(pwr_good),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe), .busy_o(busy)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_sram [DEPTH];
  int m_sh   [DEPTH];
  int m_left, m_step;
  bit m_pq, m_pst, m_prc;
  int seq_a [7] = '{'h0E38, 'h31C7, 'h03E0, 'h3C1F, 'h303F, 'h0FC0, 'h0C63};

  function automatic bit m_can_access();
    return (m_left == 0) && pwr_good && m_pq && !m_pst && !m_prc;
  endfunction

  function automatic void m_store();
    foreach (m_sh[i]) m_sh[i] = m_sram[i];
    m_left = DEPTH;
  endfunction

  function automatic void m_recall();
    foreach (m_sram[i]) m_sram[i] = m_sh[i];
    m_left = 2 * DEPTH;
  endfunction

  function automatic void m_seq(input int a);
    if (m_step == 5) begin
      if (a == seq_a[5]) begin
        m_store();
        m_step = 0;
      end else if (a == seq_a[6]) begin
        m_recall();
        m_step = 0;
      end else begin
        m_step = (a == seq_a[0]) ? 1 : 0;
      end
    end else if (a == seq_a[m_step]) begin
      m_step++;
    end else begin
      m_step = (a == seq_a[0]) ? 1 : 0;
    end
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    bit fall, rise, acc;
    if (!rst_ni) begin
      foreach (m_sram[i]) begin m_sram[i] = 0; m_sh[i] = 0; end
      m_left = 0; m_step = 0; m_pq = 0; m_pst = 0; m_prc = 0;
    end else begin
      fall = m_pq && !pwr_good;
      rise = !m_pq && pwr_good;
      acc  = m_can_access() && !ce_n;
      m_pq = pwr_good;
      m_pst = m_pst | fall;
      m_prc = m_prc | rise;
      if (m_left > 0) m_left--;
      else if (m_pst) begin m_pst = 0; m_store(); end
      else if (m_prc) begin m_prc = 0; m_recall(); end
      else if (acc) begin
        if (!we_n) begin
          m_sram[int'(addr) % DEPTH] = int'(din);
          m_step = 0;
        end else begin
          m_seq(int'(addr));
        end
      end
    end
  end

  // per-cycle comparison, just before each rising edge
  always @(negedge clk) begin
    bit exp_oe;
    #(CLK_P/2 - 1);
    exp_oe = m_can_access() && !ce_n && we_n && !oe_n;
    chk(busy === (m_left > 0), "R8/R9 busy", int'(busy), int'(m_left > 0));
    chk(doe === exp_oe, "R1/R2/R3 drive enable", int'(doe), int'(exp_oe));
    if (exp_oe)
      chk(dout === DATA_W'(m_sram[int'(addr) % DEPTH]), "R2 model data",
          int'(dout), m_sram[int'(addr) % DEPTH]);
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd(input int a);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = ADDR_W'(a);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d, input bit oe_low);
    ce_n = 1'b0; we_n = 1'b0; oe_n = !oe_low; addr = ADDR_W'(a); din = DATA_W'(d);
    @(negedge clk);
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = ADDR_W'(a);
    #(CLK_P/4);
    chk(doe === 1'b1 && dout === DATA_W'(exp), req, int'(dout), exp);
    @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy === 1'b1 && n < 10 * DEPTH) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic unlock(input int last);
    for (int k = 0; k < 5; k++) rd(seq_a[k]);
    rd(last);
    idle();
  endtask

  function automatic int pat(input int k, input int s);
    return (k * s + 3 * s + 1) & 8'hFF;
  endfunction

  task automatic fill(input int s);
    for (int k = 0; k < DEPTH; k++) wr(k, pat(k, s), k[0]);
    idle();
  endtask

  task automatic check_all(input int s, input string req);
    for (int k = 0; k < DEPTH; k++) rd_chk(k, pat(k, s), req);
    idle();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #(CLK_P/4);
    chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
    chk(doe === 1'b0, "R1 reset drive", int'(doe), 0);
    @(negedge clk);

    // R11: power-up recall
    pwr_good = 1'b1;
    @(negedge clk);
    busy_len(n);
    chk(n == 2 * DEPTH, "R11 power-up recall length", n, 2 * DEPTH);
    rd_chk(3, 0, "R11 blank after recall");

    // R1: standby with output enable low
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b0;
    #(CLK_P/4);
    chk(doe === 1'b0, "R1 standby floats", int'(doe), 0);
    @(negedge clk);

    // R4, R2: write then read back
    fill(5);
    check_all(5, "R2 readback after R4 write");
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 2; din = 8'hA5;
    #(CLK_P/4);
    chk(doe === 1'b0, "R4 write with oe low no drive", int'(doe), 0);
    @(negedge clk);
    rd_chk(2, 'hA5, "R4 write visible next cycle");
    wr(2, pat(2, 5), 1'b0);
    idle();

    // R3: internal read
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = 4;
    #(CLK_P/4);
    chk(doe === 1'b0, "R3 internal read floats", int'(doe), 0);
    @(negedge clk);
    idle();

    // R5, R8: software store; writes during busy ignored
    unlock(seq_a[5]);
    wr(1, 8'h77, 1'b1);
    idle();
    busy_len(n);
    chk(n == DEPTH - 1, "R8 store length", n + 1, DEPTH);
    check_all(5, "R8 writes ignored while busy");

    // R3 counts toward sequence: internal read as step one
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = ADDR_W'(seq_a[0]);
    @(negedge clk);
    for (int k = 1; k < 5; k++) rd(seq_a[k]);
    rd(seq_a[5]);
    idle();
    #(CLK_P/4);
    chk(busy === 1'b1, "R3 internal read counted", int'(busy), 1);
    @(negedge clk);
    busy_len(n);

    // R6, R9: overwrite then software recall
    fill(9);
    unlock(seq_a[6]);
    busy_len(n);
    chk(n == 2 * DEPTH, "R9 recall length", n, 2 * DEPTH);
    check_all(5, "R9 recall restores shadow");
    fill(11);
    unlock(seq_a[6]);
    busy_len(n);
    check_all(5, "R9 shadow unchanged by recall");

    // R7: aborts
    for (int k = 0; k < 3; k++) rd(seq_a[k]);
    wr(seq_a[3], 1, 1'b0);
    for (int k = 3; k < 5; k++) rd(seq_a[k]);
    rd(seq_a[5]);
    idle();
    #(CLK_P/4);
    chk(busy === 1'b0, "R7 write aborts", int'(busy), 0);
    @(negedge clk);
    for (int k = 0; k < 4; k++) rd(seq_a[k]);
    rd(5);
    rd(seq_a[4]);
    rd(seq_a[5]);
    idle();
    #(CLK_P/4);
    chk(busy === 1'b0, "R7 stray read aborts", int'(busy), 0);
    @(negedge clk);
    rd(seq_a[0]); rd(seq_a[1]); rd(seq_a[0]);
    for (int k = 1; k < 5; k++) rd(seq_a[k]);
    rd(seq_a[5]);
    idle();
    #(CLK_P/4);
    chk(busy === 1'b1, "R7 restart at step one", int'(busy), 1);
    @(negedge clk);
    busy_len(n);
    rd(seq_a[0]); rd(seq_a[1]);
    idle();
    repeat (3) @(negedge clk);
    for (int k = 2; k < 5; k++) rd(seq_a[k]);
    rd(seq_a[6]);
    idle();
    #(CLK_P/4);
    chk(busy === 1'b1, "R7 gaps keep progress", int'(busy), 1);
    @(negedge clk);
    busy_len(n);

    // R10, R11: power loss and return
    fill(13);
    pwr_good = 1'b0;
    @(negedge clk);
    busy_len(n);
    chk(n == DEPTH, "R10 power-fall store length", n, DEPTH);
    wr(0, 8'h3C, 1'b1);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = 0;
    #(CLK_P/4);
    chk(doe === 1'b0, "R10 no access while power low", int'(doe), 0);
    @(negedge clk);
    idle();
    pwr_good = 1'b1;
    @(negedge clk);
    busy_len(n);
    chk(n == 2 * DEPTH, "R11 power-rise recall length", n, 2 * DEPTH);
    check_all(13, "R10 power-fall image restored");

    // R12: power events during a transfer are queued
    fill(17);
    unlock(seq_a[6]);
    repeat (4) @(negedge clk);
    pwr_good = 1'b0;
    repeat (3) @(negedge clk);
    pwr_good = 1'b1;
    busy_len(n);
    @(negedge clk);
    chk(busy === 1'b1, "R12 pending store starts", int'(busy), 1);
    busy_len(n);
    chk(n == DEPTH, "R12 pending store first", n, DEPTH);
    @(negedge clk);
    busy_len(n);
    chk(n == 2 * DEPTH, "R12 pending recall second", n, 2 * DEPTH);
    check_all(13, "R12 contents after queued transfers");

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule